// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

This block is a small stored-program processor built around a single 16-bit accumulator. It executes each machine instruction as a sequence of register-transfer steps, one per clock. A program counter, a memory address register, a memory buffer register and an instruction register stage every access. Code and data live together in one word-addressable memory inside the block, with one 16-bit word per address. The memory is reached over the address register, so every operand read, indirect pointer read and write goes through the same staging path.

The instruction set covers direct loads, stores and arithmetic. Indirect forms use a memory word as the effective address. A conditional skip tests the sign of the accumulator. A jump-and-store call writes the return address into the word at its target, runs the code that follows that word, and returns by jumping indirectly through the saved word. An input port feeds the accumulator, an output port presents it with a one-cycle strobe, and a halt instruction stops the core until reset.

A host port outside the instruction path can write and read any memory word. It is used to load a program while reset is held and to inspect results after the core halts. A host write wins over a processor write to the same cycle.

Top module: `acc_cpu`

## Requirements
- R1: After reset the accumulator, program counter, staging registers and out_data are zero, halted and out_valid are low, and execution starts at address 0. An instruction word holds the opcode in bits 15:12 and the operand address X in bits 11:0. The opcodes are: 0000 call (jump-and-store), 0001 load, 0010 store, 0011 add, 0100 subtract, 0101 input, 0110 output, 0111 halt, 1000 skip, 1001 jump, 1010 clear, 1011 add-indirect, 1100 jump-indirect, 1101 load-indirect, 1110 store-indirect.
- R2: Load copies M[X] into the accumulator, add sets it to the accumulator plus M[X], and store writes the accumulator to M[X]. Loading 142 from address 4, adding 3456 from address 5 and storing to address 6 leaves 0x0E0E in M[6].
- R3: Subtract sets the accumulator to the accumulator minus M[X], modulo 2^16. For example, 0x1234 minus 0x2000 gives 0xF234.
- R4: Skip tests X bits 11:10 against the accumulator as a two's-complement value: 00 tests below zero, 01 tests equal to zero, 10 tests above zero, and 11 never skips. When the test holds, the next instruction word is skipped.
- R5: Jump continues execution at address X.
- R6: Load-indirect reads the pointer P = M[X] and loads M[P]. Add-indirect adds M[P]. Store-indirect writes the accumulator to M[P]. Jump-indirect continues at P.
- R7: Call writes the address of the word after the call into M[X] and continues at X+1. A jump-indirect through X then returns to the caller.
- R8: Input loads the accumulator from in_data. Output raises out_valid for exactly one cycle, with out_data equal to the accumulator.
- R9: Halt sets halted, which stays high until reset. After halt the program counter is frozen, no memory word is written and no output strobe occurs.
- R10: Clear sets the accumulator to zero.
- R11: Every instruction begins with a fetch of M[PC] into the instruction register, and the program counter advances by one before the instruction is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of all core registers |
| in_data | input | 16 | Value taken by the input instruction |
| out_data | output | 16 | Accumulator value latched by the output instruction |
| out_valid | output | 1 | One-cycle strobe marking a new out_data |
| halted | output | 1 | High once a halt instruction has executed |
| host_we | input | 1 | Host write enable for the shared memory |
| host_addr | input | 12 | Host read and write word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Memory word at host_addr, combinational |

## Verification
The bench builds the core with its default 16-bit word and 12-bit address, so programs can place pointers, subroutines and jump targets well away from the code at address 0. Four programs are loaded through the host port while reset is held. Together they cover direct arithmetic with a wrapping subtraction, all three skip conditions on negative, zero and positive accumulator values, and indirect access through pointers in separate memory regions. They also cover a call and return that passes back through the saved word. Output strobes are compared in order against a queue of expected values. After each halt, memory words are read back and the bench watches for any strobe after the halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = WORD_W - ADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OP_CALL   = 4'b0000,
        OP_LOAD   = 4'b0001,
        OP_STORE  = 4'b0010,
        OP_ADD    = 4'b0011,
        OP_SUB    = 4'b0100,
        OP_IN     = 4'b0101,
        OP_OUT    = 4'b0110,
        OP_HALT   = 4'b0111,
        OP_SKIP   = 4'b1000,
        OP_JUMP   = 4'b1001,
        OP_CLEAR  = 4'b1010,
        OP_ADDI   = 4'b1011,
        OP_JUMPI  = 4'b1100,
        OP_LOADI  = 4'b1101,
        OP_STOREI = 4'b1110,
        OP_SPARE  = 4'b1111
    } opcode_e;

    typedef enum logic [3:0] {
        S_F1, S_F2, S_F3, S_F4, S_D1, S_D2, S_I1, S_I2, S_EX, S_J2, S_HALT
    } step_e;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mbr;
        logic [WORD_W-1:0] ir;
        step_e             step;
        logic              halted;
        logic              out_valid;
        logic [WORD_W-1:0] out_data;
    } core_regs_t;
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we) begin
            store_q[host_addr] <= host_wdata;
        end else if (cpu_we) begin
            store_q[cpu_addr] <= cpu_wdata;
        end
    end

    assign cpu_rdata  = store_q[cpu_addr];
    assign host_rdata = store_q[host_addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] y,
    output logic         a_neg,
    output logic         a_zero
);
    always_comb begin
        if (do_sub) begin
            y = a - b;
        end else begin
            y = a + b;
        end
        a_neg  = a[W-1];
        a_zero = (a == '0);
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);
    core_regs_t        r_q, r_d;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] mem_wdata;
    logic              mem_we;
    logic [WORD_W-1:0] alu_y;
    logic              alu_sub;
    logic              ac_neg, ac_zero;
    opcode_e           opc;
    logic              take_skip;

    assign opc = opcode_e'(r_q.ir[WORD_W-1:ADDR_W]);

    acc_ram #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
        .clk       (clk),
        .cpu_addr  (r_q.mar),
        .cpu_we    (mem_we),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    assign alu_sub = (opc == OP_SUB);

    acc_alu #(.W(WORD_W)) u_alu (
        .a     (r_q.ac),
        .b     (r_q.mbr),
        .do_sub(alu_sub),
        .y     (alu_y),
        .a_neg (ac_neg),
        .a_zero(ac_zero)
    );

    always_comb begin
        case (r_q.ir[ADDR_W-1:ADDR_W-2])
            2'b00:   take_skip = ac_neg;
            2'b01:   take_skip = ac_zero;
            2'b10:   take_skip = !ac_neg && !ac_zero;
            default: take_skip = 1'b0;
        endcase
    end

    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        mem_we        = 1'b0;
        mem_wdata     = r_q.ac;
        case (r_q.step)
            S_F1: begin
                r_d.mar  = r_q.pc;
                r_d.step = S_F2;
            end
            S_F2: begin
                r_d.mbr  = mem_rdata;
                r_d.step = S_F3;
            end
            S_F3: begin
                r_d.ir   = r_q.mbr;
                r_d.step = S_F4;
            end
            S_F4: begin
                r_d.pc   = r_q.pc + 1'b1;
                r_d.step = S_D1;
            end
            S_D1: begin
                r_d.mar = r_q.ir[ADDR_W-1:0];
                case (opc)
                    OP_LOAD, OP_ADD, OP_SUB, OP_ADDI,
                    OP_LOADI, OP_STOREI, OP_JUMPI: r_d.step = S_D2;
                    OP_HALT: begin
                        r_d.halted = 1'b1;
                        r_d.step   = S_HALT;
                    end
                    default: r_d.step = S_EX;
                endcase
            end
            S_D2: begin
                r_d.mbr = mem_rdata;
                if (opc == OP_ADDI || opc == OP_LOADI || opc == OP_STOREI) begin
                    r_d.step = S_I1;
                end else begin
                    r_d.step = S_EX;
                end
            end
            S_I1: begin
                r_d.mar  = r_q.mbr[ADDR_W-1:0];
                r_d.step = (opc == OP_STOREI) ? S_EX : S_I2;
            end
            S_I2: begin
                r_d.mbr  = mem_rdata;
                r_d.step = S_EX;
            end
            S_EX: begin
                r_d.step = S_F1;
                case (opc)
                    OP_LOAD, OP_LOADI:        r_d.ac = r_q.mbr;
                    OP_ADD, OP_ADDI, OP_SUB:  r_d.ac = alu_y;
                    OP_STORE, OP_STOREI:      mem_we = 1'b1;
                    OP_IN:                    r_d.ac = in_data;
                    OP_OUT: begin
                        r_d.out_valid = 1'b1;
                        r_d.out_data  = r_q.ac;
                    end
                    OP_CLEAR:                 r_d.ac = '0;
                    OP_JUMP:                  r_d.pc = r_q.mar;
                    OP_JUMPI:                 r_d.pc = r_q.mbr[ADDR_W-1:0];
                    OP_SKIP: begin
                        if (take_skip) begin
                            r_d.pc = r_q.pc + 1'b1;
                        end
                    end
                    OP_CALL: begin
                        r_d.mbr  = {{(WORD_W-ADDR_W){1'b0}}, r_q.pc};
                        r_d.step = S_J2;
                    end
                    default: ;
                endcase
            end
            S_J2: begin
                mem_we    = 1'b1;
                mem_wdata = r_q.mbr;
                r_d.pc    = r_q.mar + 1'b1;
                r_d.step  = S_F1;
            end
            S_HALT: r_d.step = S_HALT;
            default: r_d.step = S_F1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data  = r_q.out_data;
    assign out_valid = r_q.out_valid;
    assign halted    = r_q.halted;

    // R9: once set, the halt flag holds until reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: program counter frozen while halted
    a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(r_q.pc));

    // R9: no memory write from the core after halt
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R8: output strobe lasts a single cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R11: the last fetch step advances the program counter by one
    a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.step == S_F4) |=> (r_q.pc == $past(r_q.pc) + ADDR_W'(1)));
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] in_data;
    logic [15:0] out_data;
    logic        out_valid;
    logic        halted;
    logic        host_we;
    logic [11:0] host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .halted(halted), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " halted"}, {15'd0, halted}, 16'd1);
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected output actual=%h expected=none", out_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_data !== e) begin
                    fails++;
                    $display("FAIL %s output actual=%h expected=%h", t, out_data, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; in_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 halted", {15'd0, halted}, 16'd0);
        check("R1 out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 out_data", out_data, 16'd0);

        // Program A: R2 direct arithmetic
        poke(12'h000, 16'h1004); poke(12'h001, 16'h3005);
        poke(12'h002, 16'h2006); poke(12'h003, 16'h7000);
        poke(12'h004, 16'h008E); poke(12'h005, 16'h0D80);
        poke(12'h006, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        wait_halt("R2");
        peek(12'h006, v); check("R2 sum", v, 16'h0E0E);

        // Program B: R8 input/output, R3 subtract, R10 clear, R9 halt
        enter_reset();
        check("R1 halted after reset", {15'd0, halted}, 16'd0);
        poke(12'h000, 16'h5000); poke(12'h001, 16'h6000);
        poke(12'h002, 16'h4010); poke(12'h003, 16'h6000);
        poke(12'h004, 16'hA000); poke(12'h005, 16'h6000);
        poke(12'h006, 16'h2011); poke(12'h007, 16'h7000);
        poke(12'h008, 16'h6000);
        poke(12'h010, 16'h2000); poke(12'h011, 16'hFFFF);
        in_data = 16'h1234;
        expect_out("R8 input", 16'h1234);
        expect_out("R3 subtract", 16'hF234);
        expect_out("R10 clear", 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        wait_halt("R9");
        repeat (40) @(negedge clk);
        #2;
        check("R8 pending outputs", 16'(exp_q.size()), 16'd0);
        check("R9 still halted", {15'd0, halted}, 16'd1);
        peek(12'h011, v); check("R10 stored clear", v, 16'h0000);

        // Program C: R4 skip conditions, R5 jump
        enter_reset();
        poke(12'h000, 16'h1020); poke(12'h001, 16'h8000);
        poke(12'h002, 16'h6000); poke(12'h003, 16'h8400);
        poke(12'h004, 16'hA000); poke(12'h005, 16'h8400);
        poke(12'h006, 16'h7000); poke(12'h007, 16'h8800);
        poke(12'h008, 16'h3021); poke(12'h009, 16'h8800);
        poke(12'h00A, 16'h7000); poke(12'h00B, 16'h6000);
        poke(12'h00C, 16'h9030); poke(12'h00D, 16'h7000);
        poke(12'h020, 16'hFFFB); poke(12'h021, 16'h0005);
        poke(12'h030, 16'h6000); poke(12'h031, 16'h7000);
        expect_out("R4 skip sequence", 16'h0005);
        expect_out("R5 jump target", 16'h0005);
        @(negedge clk); rst_n = 1'b1;
        wait_halt("R5");
        repeat (10) @(negedge clk);
        #2;
        check("R4 pending outputs", 16'(exp_q.size()), 16'd0);

        // Program D: R6 indirect, R7 call and return
        enter_reset();
        poke(12'h000, 16'hD040); poke(12'h001, 16'hB041);
        poke(12'h002, 16'hE042); poke(12'h003, 16'h0060);
        poke(12'h004, 16'h6000); poke(12'h005, 16'hC043);
        poke(12'h006, 16'h7000);
        poke(12'h040, 16'h0050); poke(12'h041, 16'h0051);
        poke(12'h042, 16'h0052); poke(12'h043, 16'h0070);
        poke(12'h044, 16'h0100);
        poke(12'h050, 16'h0007); poke(12'h051, 16'h0003);
        poke(12'h052, 16'h0000);
        poke(12'h060, 16'h0000); poke(12'h061, 16'h3044);
        poke(12'h062, 16'h6000); poke(12'h063, 16'hC060);
        poke(12'h070, 16'h6000); poke(12'h071, 16'h7000);
        expect_out("R7 in subroutine", 16'h010A);
        expect_out("R7 after return", 16'h010A);
        expect_out("R6 jump-indirect target", 16'h010A);
        @(negedge clk); rst_n = 1'b1;
        wait_halt("R6");
        repeat (10) @(negedge clk);
        #2;
        check("R7 pending outputs", 16'(exp_q.size()), 16'd0);
        peek(12'h052, v); check("R6 store-indirect", v, 16'h000A);
        peek(12'h060, v); check("R7 return address", v, 16'h0004);
        peek(12'h040, v); check("R6 pointer kept", v, 16'h0050);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule